// File: doc/BRIEF.md
# Synchronized Leading/Trailing Edge Dual Modulator

This block turns one master tick stream into two phase-locked gate signals for a two-stage power converter. A single free-running ramp counter supplies both stages. The back stage repeats every 2^W ticks and uses trailing-edge modulation: its gate turns on at the start of each period and turns off when the ramp reaches its command. The front stage repeats every 2^(W+1) ticks, which is exactly half the back-stage frequency. It uses leading-edge modulation: its gate is off at the start of its period and turns on once the ramp passes its command. This means the front command sets the off time.

Each stage has a cycle-by-cycle current limit. An over-current flag turns the stage's gate off at once. The gate then stays off until the start of that stage's next period. Analog ramps, amplifiers and drivers sit outside the block. A front-stage turn-off always coincides with the start of a back-stage pulse, so the two switches are placed against each other in time.

Top module: `dual_edge_modulator`

## Requirements
- R1: The shared ramp counter is W+1 bits wide, clears on reset, and advances by one only in cycles where `tick` is high. The back ramp is its low W bits, giving a period of 2^W ticks. The front ramp is the whole counter, giving a period of 2^(W+1) ticks.
- R2: The back gate is high from back-ramp value 0 while the back ramp is below `back_cmd - OFFSET`. It therefore stays on for that many ticks each back period.
- R3: The back gate is never high once the back ramp reaches 2^(W-1). This keeps the back duty cycle at or below 50 %.
- R4: A `back_cmd` less than or equal to OFFSET (default 40) gives zero back duty.
- R5: The front gate is low while the front ramp is below 2*`front_cmd` and high from there to the end of the front period.
- R6: The front gate is low for the first DEAD = ceil(2^(W+1)/10) ticks of every front period (52 at W=8), whatever the command. This caps the front duty at 90 %.
- R7: Every falling edge of the front gate happens in the same cycle as a rising edge of the back gate.
- R8: A high `back_ilim` forces `back_gate` low in the same cycle and sets `back_latched` at the next edge. The gate stays low until the edge at which the back ramp wraps to 0, which clears the latch unless `back_ilim` is still high.
- R9: `front_ilim` does the same for the front stage, with the latch cleared at the front-ramp wrap.
- R10: A low enable holds that stage's gate low and its latch clear, even while its limit flag is asserted.
- R11: During and right after reset both latches read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Master ramp advance strobe |
| back_en | input | 1 | Back-stage enable |
| front_en | input | 1 | Front-stage enable |
| back_cmd | input | W | Back-stage command word |
| front_cmd | input | W | Front-stage command word (off time, in pairs of ticks) |
| back_ilim | input | 1 | Back-stage over-current flag |
| front_ilim | input | 1 | Front-stage over-current flag |
| back_gate | output | 1 | Back-stage gate, trailing-edge modulated |
| front_gate | output | 1 | Front-stage gate, leading-edge modulated |
| back_latched | output | 1 | Back-stage limit latch state |
| front_latched | output | 1 | Front-stage limit latch state |

## Verification
The bench counts on-ticks across command values on both sides of the offset, the dead-time floor and the 50 % ceiling. It catches a design that is off by one at the comparison, drops the offset subtraction, or lets a full command run past half the back period. A limit pulse in the middle of a pulse must blank the gate for the rest of that stage's period and no longer. A latch cleared at the wrong stage's boundary would show as an early restart or a missed pulse. The bench also checks that every front turn-off lands on a back turn-on, which exposes a front divider that has drifted out of phase. Finally, it checks that a paused `tick` freezes a pulse that would otherwise have ended.

// File: rtl/dual_edge_modulator.sv
module dual_edge_modulator #(
  parameter int W      = 8,
  parameter int OFFSET = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         back_en,
  input  logic         front_en,
  input  logic [W-1:0] back_cmd,
  input  logic [W-1:0] front_cmd,
  input  logic         back_ilim,
  input  logic         front_ilim,
  output logic         back_gate,
  output logic         front_gate,
  output logic         back_latched,
  output logic         front_latched
);
  localparam int PW   = W + 1;
  localparam int DEAD = ((1 << PW) + 9) / 10;

  logic [PW-1:0] ramp;
  logic [W-1:0]  back_lvl;
  logic [PW-1:0] front_lvl;

  wire [W-1:0] back_ramp = ramp[W-1:0];
  wire back_start  = tick & (&back_ramp);
  wire front_start = tick & (&ramp);

  always_ff @(posedge clk) begin
    if (!rst_n) ramp <= '0;
    else if (tick) ramp <= ramp + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !back_en) back_latched <= 1'b0;
    else back_latched <= back_ilim | (back_latched & ~back_start);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !front_en) front_latched <= 1'b0;
    else front_latched <= front_ilim | (front_latched & ~front_start);
  end

  assign back_lvl  = (int'(back_cmd) > OFFSET) ? back_cmd - W'(OFFSET) : '0;
  assign front_lvl = {front_cmd, 1'b0};

  assign back_gate = back_en & ~back_latched & ~back_ilim
                   & ~back_ramp[W-1] & (back_ramp < back_lvl);

  assign front_gate = front_en & ~front_latched & ~front_ilim
                    & (ramp >= front_lvl) & (ramp >= PW'(DEAD));
endmodule

// File: rtl/dual_edge_modulator_chk.sv
module dual_edge_modulator_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [W:0]   ramp,
  input logic         back_ilim,
  input logic         front_ilim,
  input logic         back_gate,
  input logic         front_gate,
  input logic         back_latched,
  input logic         front_latched
);
  localparam logic [W-1:0] HALF_M1 = {1'b0, {(W-1){1'b1}}};

  assert_back_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && ramp[W-1:0] == HALF_M1 |=> !back_gate);

  assert_front_dead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (&ramp) |=> !front_gate);

  assert_back_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    back_ilim |=> !back_gate);

  assert_front_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    front_ilim |=> !front_gate);

  assert_back_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (&ramp[W-1:0]) && !back_ilim |=> !back_latched);

  assert_front_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (&ramp) && !front_ilim |=> !front_latched);

  assert_ramp_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ramp));
endmodule

bind dual_edge_modulator dual_edge_modulator_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ramp(ramp),
  .back_ilim(back_ilim), .front_ilim(front_ilim),
  .back_gate(back_gate), .front_gate(front_gate),
  .back_latched(back_latched), .front_latched(front_latched)
);

// File: tb/dual_edge_modulator_tb.sv
`timescale 1ns/1ps
module dual_edge_modulator_tb_top;
  localparam int W = 8;
  localparam int NV = 7;
  localparam int VB [NV] = '{0, 40, 41, 100, 168, 255, 60};
  localparam int VF [NV] = '{0, 25, 26, 100, 200, 255, 30};
  localparam int EB [NV] = '{0, 0, 1, 60, 128, 128, 20};
  localparam int EF [NV] = '{460, 460, 460, 312, 112, 2, 452};

  logic clk = 0, rst_n = 0, tick = 1, back_en = 0, front_en = 0;
  logic [W-1:0] back_cmd = '0, front_cmd = '0;
  logic back_ilim = 0, front_ilim = 0;
  logic back_gate, front_gate, back_latched, front_latched;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_edge_modulator #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .back_en(back_en), .front_en(front_en),
    .back_cmd(back_cmd), .front_cmd(front_cmd), .back_ilim(back_ilim),
    .front_ilim(front_ilim), .back_gate(back_gate), .front_gate(front_gate),
    .back_latched(back_latched), .front_latched(front_latched));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_on(input int n, output int cb, output int cf);
    cb = 0; cf = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cb += int'(back_gate);
      cf += int'(front_gate);
    end
  endtask

  task automatic wait_back_rise();
    logic p;
    p = back_gate;
    forever begin
      @(negedge clk);
      if (back_gate && !p) break;
      p = back_gate;
    end
  endtask

  task automatic wait_front_rise();
    logic p;
    p = front_gate;
    forever begin
      @(negedge clk);
      if (front_gate && !p) break;
      p = front_gate;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int cb, cf, falls, paired;
    logic pb, pf;
    repeat (3) @(negedge clk);
    chk(!back_latched && !front_latched, "R11 latches in reset", int'(back_latched), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!back_latched && !front_latched, "R11 latches after reset", int'(front_latched), 0);
    chk(!back_gate && !front_gate, "R10 gates off while disabled", int'(back_gate), 0);
    back_en = 1; front_en = 1;

    // R2 R3 R4 R5 R6: duty over two back periods / one front period
    for (int v = 0; v < NV; v++) begin
      back_cmd = W'(VB[v]); front_cmd = W'(VF[v]);
      @(negedge clk);
      count_on(512, cb, cf);
      chk(cb == 2 * EB[v], "R2/R3/R4 back on-ticks", cb, 2 * EB[v]);
      chk(cf == EF[v], "R5/R6 front on-ticks", cf, EF[v]);
    end

    // R7: front falls only together with a back rise
    back_cmd = 8'd100; front_cmd = 8'd30;
    @(negedge clk);
    falls = 0; paired = 0; pb = back_gate; pf = front_gate;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      if (pf && !front_gate) begin
        falls++;
        if (back_gate && !pb) paired++;
      end
      pb = back_gate; pf = front_gate;
    end
    chk(falls == 2, "R7 front falls per 1024", falls, 2);
    chk(paired == falls, "R7 falls aligned to back rise", paired, falls);

    // R8: back limit latch
    wait_back_rise();
    repeat (10) @(negedge clk);
    back_ilim = 1;
    #1 chk(!back_gate, "R8 immediate blank", int'(back_gate), 0);
    @(negedge clk);
    back_ilim = 0;
    chk(back_latched, "R8 latch set", int'(back_latched), 1);
    count_on(240, cb, cf);
    chk(cb == 0, "R8 held off to period end", cb, 0);
    repeat (20) @(negedge clk);
    chk(back_gate && !back_latched, "R8 restart next period", int'(back_gate), 1);

    // R9: front limit latch
    wait_front_rise();
    repeat (5) @(negedge clk);
    front_ilim = 1;
    #1 chk(!front_gate, "R9 immediate blank", int'(front_gate), 0);
    @(negedge clk);
    front_ilim = 0;
    chk(front_latched, "R9 latch set", int'(front_latched), 1);
    count_on(440, cb, cf);
    chk(cf == 0, "R9 held off to front period end", cf, 0);
    repeat (150) @(negedge clk);
    chk(front_gate && !front_latched, "R9 restart next front period", int'(front_gate), 1);

    // R1: paused tick freezes a running back pulse
    wait_back_rise();
    tick = 0;
    count_on(100, cb, cf);
    chk(cb == 100, "R1 ramp holds without tick", cb, 100);
    tick = 1;
    count_on(256, cb, cf);
    chk(cb == 60 - 1 || cb == 60, "R1 ramp resumes", cb, 60);

    // R10: disable blanks and ignores limits
    back_en = 0; front_en = 0;
    back_ilim = 1; front_ilim = 1;
    @(negedge clk);
    chk(!back_latched && !front_latched, "R10 latches stay clear", int'(back_latched), 0);
    back_ilim = 0; front_ilim = 0;
    count_on(512, cb, cf);
    chk(cb == 0, "R10 back disabled", cb, 0);
    chk(cf == 0, "R10 front disabled", cf, 0);

    finish_run();
  end
endmodule